// File: doc/BRIEF.md
# SPI Master Port with Transmit and Receive Queues

This block is a memory-mapped serial port that drives an SPI bus as master. Software programs a word width, a clock prescaler and an interrupt mask through a small register bus. It then pushes words into an eight-entry transmit queue. A transfer engine pops each word and shifts it out MSB first in SPI mode 0, while it captures the word coming back on the input line into an eight-entry receive queue. Software later pops the received words through the same data register.

A loopback mode connects the transmit queue directly to the receive queue and leaves the serial lines idle. It moves one word per clock. In both modes the engine holds off when the receive queue has no free slot for the word it would produce, so received data is never lost. One level-sensitive interrupt line reports queue fill levels at the half-depth mark. A separate flag reports the unsupported case in which the port is enabled as a slave.

Top module: `spi_master_fifo`

## Requirements
- R1: After reset both queues are empty. The status register reads 0x03, the raw interrupt register reads 0x08, `irq` is low, `spi_cs_n` is high and `spi_sclk` is low.
- R2: The data size field is control-0 bits [3:0], written as n. Every word pushed into the transmit queue is cut to its low n+1 bits using the size in force at the push. Every word entering the receive queue is cut again using the size in force at that moment.
- R3: The transmit queue keeps eight words in arrival order. A data write (offset 0x08) that arrives while it holds eight words is discarded.
- R4: A data read (offset 0x08) returns the oldest received word and removes it. A data read of an empty receive queue returns 0.
- R5: The status register (offset 0x0C) has these bits: bit0 transmit empty, bit1 transmit not full, bit2 receive not empty, bit3 receive full. Bit4 (busy) is set while the shifter runs, or while the port is enabled and the transmit queue is not empty.
- R6: Raw interrupt bit3 is set when the transmit queue holds 4 or fewer words, and raw bit2 when the receive queue holds 4 or more. Offset 0x18 reads the raw bits, offset 0x14 holds the 4-bit mask, and offset 0x1C reads raw AND mask.
- R7: `irq` is high exactly one clock after the raw AND mask value of the previous clock was nonzero.
- R8: Control-1 is at offset 0x04. Words move only while bit1 (enable) is set and bit2 (slave) is clear. With bit0 (loopback) set, one word moves per clock from the transmit queue to the receive queue while the receive queue has room. Otherwise the remaining words stay queued.
- R9: Writing control-1 with both bit1 and bit2 set raises `cfg_err` from the next clock on, and no word moves while `cfg_err` is high.
- R10: In serial mode `spi_sclk` idles low and has a period of 2*max(P,1) clocks, where P is the prescaler (offset 0x10, 8 bits). `spi_mosi` carries the word MSB first and changes only on falling edges. `spi_miso` is sampled on rising edges, and the sampled word is what a later data read returns.
- R11: `spi_cs_n` goes low when a serial transfer starts. It stays low across back-to-back words, rises once when the transmit queue is drained, and `spi_sclk` is never high while it is high.
- R12: Offsets 0xFE0 to 0xFFC read the identification bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one per word. The prescaler reads back its 8 bits. Offset 0x20 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq | output | 1 | Interrupt, level |
| cfg_err | output | 1 | Unsupported slave configuration |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
A register write takes effect at the clock edge that samples it. The read data for a strobe appears just after the edge that samples the strobe, so the bench compares it at the following falling edge against a queue model that was updated at that same edge. The interrupt line trails the queue levels by one clock, and loopback moves one word at each edge. The bench model applies both rules, and it compares `irq` and `cfg_err` at every falling edge. Serial transfers take 2*max(P,1) clocks per bit, so the bench waits for chip select to rise, checks the captured bits and the bit period, and then brings the model level with the drained queues.

// File: rtl/spi_pkg.sv
`timescale 1ns/1ps
package spi_pkg;
  localparam logic [11:0] OFS_CTL0 = 12'h000;
  localparam logic [11:0] OFS_CTL1 = 12'h004;
  localparam logic [11:0] OFS_DATA = 12'h008;
  localparam logic [11:0] OFS_STAT = 12'h00C;
  localparam logic [11:0] OFS_PRE  = 12'h010;
  localparam logic [11:0] OFS_MASK = 12'h014;
  localparam logic [11:0] OFS_RAW  = 12'h018;
  localparam logic [11:0] OFS_MIS  = 12'h01C;
  localparam logic [11:0] OFS_ID   = 12'hFE0;

  localparam int C1_LOOP = 0;
  localparam int C1_EN   = 1;
  localparam int C1_SLV  = 2;

  typedef struct packed {
    logic busy;
    logic rx_full;
    logic rx_nempty;
    logic tx_nfull;
    logic tx_empty;
  } stat_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h22;
      3'd1:    return 8'h10;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/spi_ring_fifo.sv
`timescale 1ns/1ps
module spi_ring_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [WIDTH-1:0]             push_data,
  input  logic                         pop,
  output logic [WIDTH-1:0]             oldest,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int IW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [IW-1:0]    head;
  logic [LW-1:0]    len;
  logic [IW-1:0]    tail;

  // depth is a power of two, so index arithmetic wraps naturally
  assign tail   = head - IW'(len);
  assign oldest = mem[tail];
  assign level  = len;

  always_ff @(posedge clk) begin
    if (push) mem[head] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      len  <= '0;
    end else begin
      if (push) head <= head + IW'(1);
      if (push && !pop)      len <= len + LW'(1);
      else if (pop && !push) len <= len - LW'(1);
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (len != FULL || pop));
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (len != '0));
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
  parameter int WIDTH = 16,
  parameter int PRE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [WIDTH-1:0]            load_word,
  input  logic [$clog2(WIDTH+1)-1:0]  load_bits,
  input  logic [PRE_W-1:0]            prescale,
  input  logic                        miso,
  output logic                        ready,
  output logic                        finish,
  output logic                        active,
  output logic                        sclk,
  output logic                        mosi,
  output logic [WIDTH-1:0]            rx_word
);
  localparam int BW = $clog2(WIDTH+1);

  logic [WIDTH-1:0] tx_sh, rx_sh;
  logic [BW-1:0]    bits_left;
  logic [PRE_W-1:0] hc;
  logic [PRE_W-1:0] half_m1;
  logic             edge_now;

  assign half_m1  = (prescale == '0) ? '0 : prescale - PRE_W'(1);
  assign edge_now = active && (hc == '0);
  assign finish   = edge_now && sclk && (bits_left == BW'(1));
  assign ready    = !active || finish;
  assign mosi     = tx_sh[WIDTH-1];
  assign rx_word  = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      sclk      <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      bits_left <= '0;
      hc        <= '0;
    end else if (load && ready) begin
      active    <= 1'b1;
      sclk      <= 1'b0;
      tx_sh     <= load_word << (BW'(WIDTH) - load_bits);
      rx_sh     <= '0;
      bits_left <= load_bits;
      hc        <= half_m1;
    end else if (finish) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      tx_sh  <= tx_sh << 1;
    end else if (edge_now) begin
      hc <= half_m1;
      if (!sclk) begin
        sclk  <= 1'b1;
        rx_sh <= {rx_sh[WIDTH-2:0], miso};
      end else begin
        sclk      <= 1'b0;
        tx_sh     <= tx_sh << 1;
        bits_left <= bits_left - BW'(1);
      end
    end else if (active) begin
      hc <= hc - PRE_W'(1);
    end
  end

  // R10
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));
  // R10
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sclk);
endmodule

// File: rtl/spi_master_fifo.sv
`timescale 1ns/1ps
module spi_master_fifo
  import spi_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int PRE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [11:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              cfg_err,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  localparam int SZW = $clog2(DATA_W);
  localparam int BW  = $clog2(DATA_W+1);
  localparam int LW  = $clog2(FIFO_DEPTH+1);
  localparam logic [LW-1:0] FULL_LVL = LW'(FIFO_DEPTH);
  localparam logic [LW-1:0] HALF_LVL = LW'(FIFO_DEPTH/2);

  logic [SZW-1:0]    dss;
  logic [3:0]        ctl1;
  logic [PRE_W-1:0]  prescale;
  logic [3:0]        imask;
  logic              cfg_err_q, irq_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;

  logic [DATA_W-1:0] wmask, tx_oldest, rx_oldest, rx_in, shf_rx;
  logic [LW-1:0]     tx_lvl, rx_lvl;
  logic              wr_data, rd_data, tx_push, tx_pop, rx_push, rx_pop;
  logic              eng_on, lb_move, ser_go, take;
  logic              shf_ready, shf_finish, shf_active;
  logic [3:0]        raw;
  stat_t             stat;

  assign wmask   = {DATA_W{1'b1}} >> (DATA_W - 1 - int'(dss));
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign rd_data = bus_rd && (bus_addr == OFS_DATA);
  assign tx_push = wr_data && (tx_lvl != FULL_LVL);
  assign rx_pop  = rd_data && (rx_lvl != '0);

  // engine control: loopback bypasses the shifter, serial reserves a slot
  assign eng_on  = ctl1[C1_EN] && !ctl1[C1_SLV];
  assign lb_move = eng_on && ctl1[C1_LOOP] && !shf_active &&
                   (tx_lvl != '0) && (rx_lvl != FULL_LVL);
  assign ser_go  = eng_on && !ctl1[C1_LOOP] && (tx_lvl != '0) &&
                   (({1'b0, rx_lvl} + {{LW{1'b0}}, shf_active}) < {1'b0, FULL_LVL});
  assign take    = ser_go && shf_ready;
  assign tx_pop  = lb_move || take;
  assign rx_push = lb_move || shf_finish;
  assign rx_in   = (lb_move ? tx_oldest : shf_rx) & wmask;

  spi_ring_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .push(tx_push), .push_data(bus_wdata & wmask),
    .pop(tx_pop), .oldest(tx_oldest), .level(tx_lvl));

  spi_ring_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .push(rx_push), .push_data(rx_in),
    .pop(rx_pop), .oldest(rx_oldest), .level(rx_lvl));

  spi_shift_engine #(.WIDTH(DATA_W), .PRE_W(PRE_W)) u_shift (
    .clk(clk), .rst(rst), .load(take), .load_word(tx_oldest),
    .load_bits(BW'(dss) + BW'(1)), .prescale(prescale), .miso(spi_miso),
    .ready(shf_ready), .finish(shf_finish), .active(shf_active),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx_word(shf_rx));

  assign raw = {tx_lvl <= HALF_LVL, rx_lvl >= HALF_LVL, 2'b00};

  always_comb begin
    stat.busy      = shf_active || (eng_on && tx_lvl != '0);
    stat.rx_full   = (rx_lvl == FULL_LVL);
    stat.rx_nempty = (rx_lvl != '0);
    stat.tx_nfull  = (tx_lvl != FULL_LVL);
    stat.tx_empty  = (tx_lvl == '0);
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr >= OFS_ID) begin
      rd_mux = DATA_W'(id_byte(bus_addr[4:2]));
    end else begin
      case (bus_addr)
        OFS_CTL0: rd_mux = DATA_W'(dss);
        OFS_CTL1: rd_mux = DATA_W'(ctl1);
        OFS_DATA: rd_mux = (rx_lvl != '0) ? rx_oldest : '0;
        OFS_STAT: rd_mux = DATA_W'(stat);
        OFS_PRE:  rd_mux = DATA_W'(prescale);
        OFS_MASK: rd_mux = DATA_W'(imask);
        OFS_RAW:  rd_mux = DATA_W'(raw);
        OFS_MIS:  rd_mux = DATA_W'(raw & imask);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dss       <= '0;
      ctl1      <= '0;
      prescale  <= '0;
      imask     <= '0;
      cfg_err_q <= 1'b0;
      irq_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      irq_q <= |(raw & imask);
      if (bus_rd) rdata_q <= rd_mux;
      if (bus_wr) begin
        case (bus_addr)
          OFS_CTL0: dss <= bus_wdata[SZW-1:0];
          OFS_CTL1: begin
            ctl1      <= bus_wdata[3:0];
            cfg_err_q <= bus_wdata[C1_EN] && bus_wdata[C1_SLV];
          end
          OFS_PRE:  prescale <= bus_wdata[PRE_W-1:0];
          OFS_MASK: imask    <= bus_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
  assign cfg_err   = cfg_err_q;
  assign spi_cs_n  = ~shf_active;

  // R9
  cfg_block_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !tx_pop);
  // R8
  rx_room_chk: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> (rx_lvl != FULL_LVL || rx_pop));
  // R11
  cs_sclk_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);
endmodule

// File: tb/spi_master_fifo_bench.sv
`timescale 1ns/1ps
module spi_master_fifo_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        spi_miso = 1'b0;
  wire  [15:0] bus_rdata;
  wire         irq, cfg_err, spi_sclk, spi_mosi, spi_cs_n;

  spi_master_fifo u_spi_master_fifo (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cfg_err(cfg_err),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  int checks = 0, failures = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // reference model
  int txq[$], rxq[$];
  int m_dss = 0, m_ctl1 = 0, m_pre = 0, m_mask = 0;
  int exp_rdata = 0;
  bit exp_irq = 0;
  bit hold = 0;
  int ids[8] = '{'h22, 'h10, 'h04, 'h00, 'h0D, 'hF0, 'h05, 'hB1};

  function automatic int wm(int d);
    return (1 << (d + 1)) - 1;
  endfunction

  function automatic int m_raw();
    return ((txq.size() <= 4) ? 8 : 0) | ((rxq.size() >= 4) ? 4 : 0);
  endfunction

  function automatic int m_read(int a);
    bit on;
    on = m_ctl1[1] && !m_ctl1[2];
    if (a >= 'hFE0) return ids[(a - 'hFE0) >> 2];
    case (a)
      'h00: return m_dss;
      'h04: return m_ctl1;
      'h08: return (rxq.size() != 0) ? rxq[0] : 0;
      'h0C: return ((on && txq.size() > 0) ? 16 : 0) | ((rxq.size() == 8) ? 8 : 0) |
                   ((rxq.size() != 0) ? 4 : 0) | ((txq.size() != 8) ? 2 : 0) |
                   ((txq.size() == 0) ? 1 : 0);
      'h10: return m_pre;
      'h14: return m_mask;
      'h18: return m_raw();
      'h1C: return m_raw() & m_mask;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int tn, rn;
    bit go, nirq;
    if (rst) begin
      txq.delete(); rxq.delete();
      m_dss = 0; m_ctl1 = 0; m_pre = 0; m_mask = 0; exp_irq = 0;
    end else begin
      tn = txq.size(); rn = rxq.size();
      nirq = (m_raw() & m_mask) != 0;
      if (bus_rd) exp_rdata = m_read(int'(bus_addr));
      go = !hold && m_ctl1[1] && m_ctl1[0] && !m_ctl1[2] && tn > 0 && rn < 8;
      if (bus_rd && bus_addr == 12'h008 && rn > 0) void'(rxq.pop_front());
      if (go) rxq.push_back(txq.pop_front() & wm(m_dss));
      if (bus_wr) begin
        case (int'(bus_addr))
          'h00: m_dss  = int'(bus_wdata) & 15;
          'h04: m_ctl1 = int'(bus_wdata) & 15;
          'h08: if (tn < 8) txq.push_back(int'(bus_wdata) & wm(m_dss));
          'h10: m_pre  = int'(bus_wdata) & 255;
          'h14: m_mask = int'(bus_wdata) & 15;
          default: ;
        endcase
      end
      exp_irq = nirq;
    end
  end

  // R7 and R9 compared on every clock
  always @(negedge clk) begin
    if (!rst && !hold) begin
      check("R7", "irq", int'(irq), int'(exp_irq));
      check("R9", "cfg_err", int'(cfg_err), int'(m_ctl1[1] && m_ctl1[2]));
    end
  end

  // serial slave model
  int resp[$], got[$];
  logic [7:0] s_cur = '0, s_cap = '0;
  int s_bit = 0, rises = 0, cs_rises = 0;
  realtime t_last = 0, period = 0;

  always @(negedge spi_cs_n) begin
    s_bit = 0;
    s_cur = (resp.size() != 0) ? 8'(resp.pop_front()) : 8'h00;
    spi_miso = s_cur[7];
  end
  always @(posedge spi_sclk) begin
    s_cap = {s_cap[6:0], spi_mosi};
    s_bit++;
    if (s_bit == 8) begin got.push_back(int'(s_cap)); s_bit = 0; end
    rises++;
    if (rises == 2) period = $realtime - t_last;
    t_last = $realtime;
  end
  always @(negedge spi_sclk) begin
    if (s_bit == 0) s_cur = (resp.size() != 0) ? 8'(resp.pop_front()) : 8'h00;
    else s_cur = s_cur << 1;
    spi_miso = s_cur[7];
  end
  always @(posedge spi_cs_n) cs_rises++;

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(int a, string req, string what);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 12'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, what, int'(bus_rdata), exp_rdata);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "cs_n", int'(spi_cs_n), 1);
    check("R1", "sclk", int'(spi_sclk), 0);
    check("R1", "irq", int'(irq), 0);
    rd_chk('h0C, "R1", "status");
    check("R1", "status value", int'(bus_rdata), 'h03);
    rd_chk('h18, "R1", "raw");
    check("R1", "raw value", int'(bus_rdata), 'h08);

    // R12 identification, prescaler, unmapped
    for (int i = 0; i < 8; i++) rd_chk('hFE0 + 4 * i, "R12", "id byte");
    check("R12", "id last", int'(bus_rdata), 'hB1);
    wr('h10, 'h1AB);
    rd_chk('h10, "R12", "prescaler");
    check("R12", "prescaler value", int'(bus_rdata), 'hAB);
    wr('h20, 'h3);
    rd_chk('h20, "R12", "dma offset");
    rd_chk('h24, "R12", "unmapped");

    // R2 R3 fill while disabled, ninth write dropped
    wr('h00, 7);
    for (int i = 0; i < 9; i++) wr('h08, 'h1F0 + i);
    rd_chk('h0C, "R3", "status full tx");
    check("R5", "status full tx value", int'(bus_rdata), 'h00);
    wr('h14, 'hC);
    rd_chk('h1C, "R6", "masked with tx full");

    // R8 loopback drain, stall at rx full
    wr('h04, 'h3);
    repeat (12) @(negedge clk);
    rd_chk('h0C, "R5", "status rx full");
    rd_chk('h1C, "R6", "masked rx");
    wr('h08, 'hAA);
    wr('h08, 'hBB);
    repeat (3) @(negedge clk);
    rd_chk('h0C, "R8", "stalled status");
    check("R8", "stalled value", int'(bus_rdata), 'h1E);
    for (int i = 0; i < 10; i++) rd_chk('h08, "R4", "rx order");
    check("R4", "last word", int'(bus_rdata), 'hBB);
    rd_chk('h08, "R4", "empty read");
    check("R4", "empty value", int'(bus_rdata), 0);

    // R2 receive-side cut with narrower size
    wr('h04, 0);
    wr('h00, 15);
    wr('h08, 'hBEEF);
    wr('h08, 'h1234);
    wr('h00, 3);
    wr('h04, 'h3);
    repeat (4) @(negedge clk);
    rd_chk('h08, "R2", "rx cut 1");
    check("R2", "rx cut 1 value", int'(bus_rdata), 'hF);
    rd_chk('h08, "R2", "rx cut 2");

    // R9 slave plus enable
    wr('h04, 'h6);
    wr('h08, 'h5);
    repeat (5) @(negedge clk);
    check("R9", "cfg_err high", int'(cfg_err), 1);
    rd_chk('h0C, "R9", "no move status");
    check("R9", "tx kept", int'(bus_rdata), 'h02);
    wr('h04, 'h3);
    repeat (3) @(negedge clk);
    rd_chk('h08, "R8", "drained after fix");

    // R10 R11 serial transfers
    wr('h04, 0);
    @(negedge clk);
    hold = 1'b1;
    wr('h00, 7);
    wr('h10, 3);
    resp = '{'h5A, 'hC3, 'h7E};
    wr('h08, 'hA5);
    wr('h08, 'h3C);
    wr('h08, 'h81);
    rises = 0; cs_rises = 0;
    wr('h04, 'h2);
    @(posedge spi_cs_n);
    repeat (4) @(negedge clk);
    check("R10", "mosi words", got.size(), 3);
    if (got.size() == 3) begin
      check("R10", "mosi 0", got[0], 'hA5);
      check("R10", "mosi 1", got[1], 'h3C);
      check("R10", "mosi 2", got[2], 'h81);
    end
    check("R10", "sclk period ns", int'(period), 30);
    check("R11", "cs rises", cs_rises, 1);
    check("R11", "cs idle high", int'(spi_cs_n), 1);
    @(posedge clk);
    #1;
    txq.delete();
    rxq.delete();
    rxq.push_back('h5A); rxq.push_back('hC3); rxq.push_back('h7E);
    exp_irq = (m_raw() & m_mask) != 0;
    hold = 1'b0;
    rd_chk('h08, "R10", "miso 0");
    check("R10", "miso 0 value", int'(bus_rdata), 'h5A);
    rd_chk('h08, "R10", "miso 1");
    rd_chk('h08, "R10", "miso 2");
    rd_chk('h0C, "R5", "status after serial");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule